// File: doc/BRIEF.md
# Tile Layer Pixel Generator

This block produces the colour-index stream of a hardware character layer. For each display pixel it takes a column and line counter, applies the horizontal and vertical scroll, looks up the covering cell in a character map held in video memory, fetches the matching glyph byte, and outputs an 8-bit colour index together with a transparency flag. The map and the glyph set both live in one 16 KB video bank, each starting at a base that is a multiple of 256 bytes.

Two screen layouts are supported: 80 cells by 32 rows (640x256 pixels) and 40 cells by 32 rows (320x256 pixels). In the normal mode glyphs carry 4 bits per pixel, and each cell's attribute byte can mirror the glyph on either axis and rotate it by a quarter turn. In the monochrome mode these transforms are dropped and glyphs hold 1 bit per pixel, while the attribute byte supplies a wider palette offset. The block issues one map read and one glyph read per pixel through two synchronous read ports with one cycle of latency. It accepts one pixel on every clock, and output does not stall at cell boundaries.

Top module: `tilemap_gen`

## Requirements
- R1: While reset is held and after it is released with no pixel requested, `pix_valid`, `map_rd_en` and `glyph_rd_en` are 0, and `pix_colour` and `pix_transparent` are 0.
- R2: A pixel sampled with `pix_en`=1 at clock edge k has its result registered at edge k+4 with `pix_valid`=1. Consecutive pixels give consecutive results with no idle cycles, and `pix_valid` is `pix_en` delayed by four edges.
- R3: The scrolled column is sx = (pix_x + scroll_x) mod W. W is 640 when `wide`=1 and 320 when `wide`=0, and `scroll_x` may take any 10-bit value.
- R4: The scrolled line is sy = (pix_y + scroll_y) mod 256.
- R5: The map word address is (map_base*128 + (sy/8)*C + sx/8) mod 8192, where C is 80 when `wide`=1 and 40 otherwise. The low byte of the returned 16-bit word is the glyph index and the high byte is the attribute.
- R6: In 4-bit mode (`mono`=0), the glyph byte address is (glyph_base*256 + index*32 + gr*4 + gc/2) mod 16384. An even gc selects bits 7:4 and an odd gc selects bits 3:0. The colour is {attr[7:4], nibble}.
- R7: In 4-bit mode, with u=sx mod 8 and v=sy mod 8: attr[3] replaces u by 7-u and attr[2] replaces v by 7-v. After that, attr[1]=1 gives gc=v and gr=7-u, and attr[1]=0 gives gc=u and gr=v.
- R8: In monochrome mode (`mono`=1), the glyph byte address is (glyph_base*256 + index*8 + v) mod 16384 and the pixel bit is bit 7-u. The colour is {attr[7:1], bit}. Attribute bits 3:1 cause no transform.
- R9: `pix_transparent` is 1 exactly when bits 3:0 of the output colour equal `trans_idx`.
- R10: A cycle whose result slot carries `pix_valid`=0 leaves `pix_colour` and `pix_transparent` unchanged.
- R11: `mono`, `wide`, the scroll values and `map_base` are captured with each pixel, so a change between two adjacent pixels affects only the later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | A pixel is requested this cycle |
| pix_x | input | 10 | Display column of the requested pixel |
| pix_y | input | 8 | Display line of the requested pixel |
| wide | input | 1 | 1: 80-cell layout, 0: 40-cell layout |
| mono | input | 1 | 1: monochrome glyphs, 0: 4-bit glyphs |
| scroll_x | input | 10 | Horizontal scroll in pixels |
| scroll_y | input | 8 | Vertical scroll in pixels |
| map_base | input | 6 | Map start in the bank, in 256-byte units |
| glyph_base | input | 6 | Glyph start in the bank, in 256-byte units |
| trans_idx | input | 4 | Low colour nibble treated as transparent |
| map_rd_en | output | 1 | Map read strobe |
| map_addr | output | 13 | Map word address (16-bit words) |
| map_rdata | input | 16 | Map word returned one cycle after the strobe |
| glyph_rd_en | output | 1 | Glyph read strobe |
| glyph_addr | output | 14 | Glyph byte address |
| glyph_rdata | input | 8 | Glyph byte returned one cycle after the strobe |
| pix_valid | output | 1 | Result slot carries a pixel |
| pix_colour | output | 8 | Colour index |
| pix_transparent | output | 1 | Pixel is transparent |

## Verification
A wrong scroll wrap or map address changes the colour of whole 8-pixel runs. The error appears four cycles after the affected pixel is requested, and a wrap error appears first at the column or line where the wrap happens. A wrong glyph address, nibble choice or transform shows up as a wrong colour on single pixels inside a cell, so the bench sweeps every column of every in-cell line under attribute bytes that vary from cell to cell. A misaligned pipeline stage combines a map entry with the wrong pixel position, and the next pixel's comparison exposes it.

// File: rtl/tmap_pkg.sv
`timescale 1ns/1ps
package tmap_pkg;

  localparam int CELL_SH  = 3;          // cells are 8x8 pixels
  localparam int COLOUR_W = 8;

  // position inside a cell plus the per-pixel mode bit
  typedef struct packed {
    logic [2:0] u;
    logic [2:0] v;
    logic       mono;
  } cell_pos_t;

  // what the output stage needs to pick a pixel from the glyph byte
  typedef struct packed {
    logic [2:0] sel;
    logic [6:0] pal;
    logic       mono;
  } pick_t;

endpackage

// File: rtl/tmap_addr_stage.sv
`timescale 1ns/1ps
module tmap_addr_stage
  import tmap_pkg::*;
#(
  parameter int COLS_WIDE   = 80,
  parameter int COLS_NARROW = 40,
  parameter int ROWS        = 32,
  parameter int BANK_AW     = 14,
  parameter int BASE_LSB    = 8,
  localparam int XW  = $clog2(COLS_WIDE * 8),
  localparam int YW  = $clog2(ROWS * 8),
  localparam int MAW = BANK_AW - 1,
  localparam int BW  = BANK_AW - BASE_LSB
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           pix_en,
  input  logic [XW-1:0]  pix_x,
  input  logic [YW-1:0]  pix_y,
  input  logic           wide,
  input  logic           mono,
  input  logic [XW-1:0]  scroll_x,
  input  logic [YW-1:0]  scroll_y,
  input  logic [BW-1:0]  map_base,
  output logic           s0_valid,
  output cell_pos_t      s0_pos,
  output logic [MAW-1:0] map_addr
);

  localparam int SW     = XW + 1;
  localparam int W_WIDE = COLS_WIDE * 8;
  localparam int W_NARR = COLS_NARROW * 8;
  localparam int NRED   = (1 << SW) / W_NARR + 1;
  localparam int MLO    = MAW - BW;   // map_base is in 256-byte units

  logic [SW-1:0]  span, sx;
  logic [YW-1:0]  sy;
  logic [MAW-1:0] cell_off, addr_d;
  cell_pos_t      pos_d;

  // next state: scroll, wrap and map address
  always_comb begin
    span = wide ? SW'(W_WIDE) : SW'(W_NARR);
    sx   = SW'(pix_x) + SW'(scroll_x);
    for (int i = 0; i < NRED; i++) begin
      if (sx >= span) sx = sx - span;
    end
    // ROWS*8 is a power of two, so the line wraps by truncation
    sy       = pix_y + scroll_y;
    cell_off = MAW'(sy[YW-1:CELL_SH]) * MAW'(wide ? COLS_WIDE : COLS_NARROW)
             + MAW'(sx[SW-1:CELL_SH]);
    addr_d   = (MAW'(map_base) << MLO) + cell_off;
    pos_d.u    = sx[2:0];
    pos_d.v    = sy[2:0];
    pos_d.mono = mono;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_valid <= 1'b0;
      s0_pos   <= '0;
      map_addr <= '0;
    end else begin
      s0_valid <= pix_en;
      if (pix_en) begin
        s0_pos   <= pos_d;
        map_addr <= addr_d;
      end
    end
  end

  // R5: every map read falls inside the map area of the layout in use
  p_map_window_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    s0_valid |-> (MAW'(map_addr - (MAW'($past(map_base)) << MLO)) <
                  ($past(wide) ? MAW'(ROWS * COLS_WIDE) : MAW'(ROWS * COLS_NARROW))));

endmodule

// File: rtl/tmap_glyph_stage.sv
`timescale 1ns/1ps
module tmap_glyph_stage
  import tmap_pkg::*;
#(
  parameter int BANK_AW  = 14,
  parameter int BASE_LSB = 8,
  localparam int BW = BANK_AW - BASE_LSB
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               in_valid,
  input  cell_pos_t          in_pos,
  input  logic [15:0]        map_rdata,
  input  logic [BW-1:0]      glyph_base,
  output logic               glyph_rd_en,
  output logic [BANK_AW-1:0] glyph_addr,
  output pick_t              out_pick
);

  localparam int MONO_SPAN = 256 * 8;

  logic         a_valid;
  cell_pos_t    a_pos;
  logic [7:0]   idx, attr;
  logic [2:0]   u1, v1, gc, gr;
  logic [BANK_AW-1:0] off, addr_d;
  pick_t        pick_d;
  logic         unused_attr_bit;

  // align the cell position with the map word returning from memory
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_valid <= 1'b0;
      a_pos   <= '0;
    end else begin
      a_valid <= in_valid;
      if (in_valid) a_pos <= in_pos;
    end
  end

  // next state: decode attributes, transform, glyph address
  always_comb begin
    idx  = map_rdata[7:0];
    attr = map_rdata[15:8];
    u1   = attr[3] ? ~a_pos.u : a_pos.u;
    v1   = attr[2] ? ~a_pos.v : a_pos.v;
    if (a_pos.mono) begin
      gc         = a_pos.u;
      gr         = a_pos.v;
      off        = BANK_AW'({idx, 3'b000}) + BANK_AW'(gr);
      pick_d.pal = attr[7:1];
    end else begin
      if (attr[1]) begin
        gc = v1;
        gr = ~u1;
      end else begin
        gc = u1;
        gr = v1;
      end
      off        = BANK_AW'({idx, 5'b00000}) + BANK_AW'({gr, 2'b00}) + BANK_AW'(gc[2:1]);
      pick_d.pal = {3'b000, attr[7:4]};
    end
    pick_d.sel  = gc;
    pick_d.mono = a_pos.mono;
    addr_d      = (BANK_AW'(glyph_base) << BASE_LSB) + off;
  end

  assign unused_attr_bit = attr[0];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      glyph_rd_en <= 1'b0;
      glyph_addr  <= '0;
      out_pick    <= '0;
    end else begin
      glyph_rd_en <= a_valid;
      if (a_valid) begin
        glyph_addr <= addr_d;
        out_pick   <= pick_d;
      end
    end
  end

  // R8: monochrome reads stay within 8 bytes per glyph of the glyph base
  p_mono_window_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (glyph_rd_en && out_pick.mono) |->
      (BANK_AW'(glyph_addr - (BANK_AW'($past(glyph_base)) << BASE_LSB)) < BANK_AW'(MONO_SPAN)));

  // R7: a rotate or mirror pick only exists in 4-bit mode, where pal tops at 15
  p_pal_range_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (glyph_rd_en && !out_pick.mono) |-> (out_pick.pal[6:4] == 3'b000));

endmodule

// File: rtl/tmap_pixel_stage.sv
`timescale 1ns/1ps
module tmap_pixel_stage
  import tmap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                in_valid,
  input  pick_t               in_pick,
  input  logic [7:0]          glyph_rdata,
  input  logic [3:0]          trans_idx,
  output logic                pix_valid,
  output logic [COLOUR_W-1:0] pix_colour,
  output logic                pix_transparent
);

  logic                b_valid;
  pick_t               b_pick;
  logic [3:0]          nib;
  logic                bit_v;
  logic [COLOUR_W-1:0] colour_d;
  logic                transp_d;

  // align the pick data with the glyph byte returning from memory
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      b_valid <= 1'b0;
      b_pick  <= '0;
    end else begin
      b_valid <= in_valid;
      if (in_valid) b_pick <= in_pick;
    end
  end

  always_comb begin
    nib      = b_pick.sel[0] ? glyph_rdata[3:0] : glyph_rdata[7:4];
    bit_v    = glyph_rdata[~b_pick.sel];
    colour_d = b_pick.mono ? {b_pick.pal, bit_v} : {b_pick.pal[3:0], nib};
    transp_d = (colour_d[3:0] == trans_idx);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid       <= 1'b0;
      pix_colour      <= '0;
      pix_transparent <= 1'b0;
    end else begin
      pix_valid <= b_valid;
      if (b_valid) begin
        pix_colour      <= colour_d;
        pix_transparent <= transp_d;
      end
    end
  end

  // R10: an empty slot keeps the previous result on the outputs
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !b_valid |=> ($stable(pix_colour) && $stable(pix_transparent)));

  // R9: the flag tracks the low nibble against the key used at that edge
  p_transp_key_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pix_valid) |-> (pix_transparent == (pix_colour[3:0] == $past(trans_idx))));

endmodule

// File: rtl/tilemap_gen.sv
`timescale 1ns/1ps
module tilemap_gen
  import tmap_pkg::*;
#(
  parameter int COLS_WIDE   = 80,
  parameter int COLS_NARROW = 40,
  parameter int ROWS        = 32,
  parameter int BANK_AW     = 14,
  parameter int BASE_LSB    = 8,
  localparam int XW  = $clog2(COLS_WIDE * 8),
  localparam int YW  = $clog2(ROWS * 8),
  localparam int MAW = BANK_AW - 1,
  localparam int BW  = BANK_AW - BASE_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_en,
  input  logic [XW-1:0]       pix_x,
  input  logic [YW-1:0]       pix_y,
  input  logic                wide,
  input  logic                mono,
  input  logic [XW-1:0]       scroll_x,
  input  logic [YW-1:0]       scroll_y,
  input  logic [BW-1:0]       map_base,
  input  logic [BW-1:0]       glyph_base,
  input  logic [3:0]          trans_idx,
  output logic                map_rd_en,
  output logic [MAW-1:0]      map_addr,
  input  logic [15:0]         map_rdata,
  output logic                glyph_rd_en,
  output logic [BANK_AW-1:0]  glyph_addr,
  input  logic [7:0]          glyph_rdata,
  output logic                pix_valid,
  output logic [COLOUR_W-1:0] pix_colour,
  output logic                pix_transparent
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cell_pos_t s0_pos;
  pick_t     s1_pick;

  tmap_addr_stage #(
    .COLS_WIDE(COLS_WIDE), .COLS_NARROW(COLS_NARROW), .ROWS(ROWS),
    .BANK_AW(BANK_AW), .BASE_LSB(BASE_LSB)
  ) u_addr (
    .clk(clk), .rst_ni(rst_ni), .pix_en(pix_en), .pix_x(pix_x), .pix_y(pix_y),
    .wide(wide), .mono(mono), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .map_base(map_base), .s0_valid(map_rd_en), .s0_pos(s0_pos), .map_addr(map_addr)
  );

  tmap_glyph_stage #(.BANK_AW(BANK_AW), .BASE_LSB(BASE_LSB)) u_glyph (
    .clk(clk), .rst_ni(rst_ni), .in_valid(map_rd_en), .in_pos(s0_pos),
    .map_rdata(map_rdata), .glyph_base(glyph_base),
    .glyph_rd_en(glyph_rd_en), .glyph_addr(glyph_addr), .out_pick(s1_pick)
  );

  tmap_pixel_stage u_pixel (
    .clk(clk), .rst_ni(rst_ni), .in_valid(glyph_rd_en), .in_pick(s1_pick),
    .glyph_rdata(glyph_rdata), .trans_idx(trans_idx),
    .pix_valid(pix_valid), .pix_colour(pix_colour), .pix_transparent(pix_transparent)
  );

  // edges since reset release, saturating; bounds the $past windows below
  logic [2:0] live_cnt;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)               live_cnt <= '0;
    else if (live_cnt != 3'd7) live_cnt <= live_cnt + 3'd1;
  end

  // R2: result slot follows the request by exactly four edges
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (live_cnt >= 3'd5) |-> (pix_valid == $past(pix_en, 5)));

  // R2: glyph fetch trails the map fetch by two cycles, one for one
  p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (live_cnt >= 3'd5) |-> (glyph_rd_en == $past(map_rd_en, 2)));

endmodule

// File: tb/tilemap_gen_test.sv
`timescale 1ns/1ps
module tilemap_gen_test;

  localparam int LAT = 5;   // negedges from drive to visible result

  logic        clk, rst_n;
  logic        pix_en, wide, mono;
  logic [9:0]  pix_x, scroll_x;
  logic [7:0]  pix_y, scroll_y;
  logic [5:0]  map_base, glyph_base;
  logic [3:0]  trans_idx;
  logic        map_rd_en, glyph_rd_en;
  logic [12:0] map_addr;
  logic [13:0] glyph_addr;
  logic [15:0] map_rdata;
  logic [7:0]  glyph_rdata;
  logic        pix_valid, pix_transparent;
  logic [7:0]  pix_colour;

  int checks = 0, failures = 0, n = 0;
  bit done = 0;
  bit    exp_v [8];
  int    exp_c [8];
  bit    exp_t [8];
  string exp_tag [8];
  int    last_c = 0;
  bit    last_t = 0;

  tilemap_gen uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_x(pix_x), .pix_y(pix_y),
    .wide(wide), .mono(mono), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .map_base(map_base), .glyph_base(glyph_base), .trans_idx(trans_idx),
    .map_rd_en(map_rd_en), .map_addr(map_addr), .map_rdata(map_rdata),
    .glyph_rd_en(glyph_rd_en), .glyph_addr(glyph_addr), .glyph_rdata(glyph_rdata),
    .pix_valid(pix_valid), .pix_colour(pix_colour), .pix_transparent(pix_transparent)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bank contents are a fixed function of the byte address
  function automatic int bank_byte(input int a);
    int b;
    b = a & 16383;
    return ((b * 73) + (b >> 8)) & 255 ^ 'h5a;
  endfunction

  always @(posedge clk) begin
    if (map_rd_en)
      map_rdata <= {8'(bank_byte(2 * int'(map_addr) + 1)), 8'(bank_byte(2 * int'(map_addr)))};
    if (glyph_rd_en)
      glyph_rdata <= 8'(bank_byte(int'(glyph_addr)));
  end

  // expected {transparent, colour} from the requirements
  function automatic int expect_px(input int x, input int y, input int wd, input int mo);
    int w, cols, sx, sy, wa, idx, at, u, v, c, r, ga, val, col;
    w    = wd ? 640 : 320;
    cols = wd ? 80 : 40;
    sx   = (x + int'(scroll_x)) % w;                       // R3
    sy   = (y + int'(scroll_y)) % 256;                     // R4
    wa   = (int'(map_base) * 128 + (sy / 8) * cols + sx / 8) % 8192;  // R5
    idx  = bank_byte(2 * wa);
    at   = bank_byte(2 * wa + 1);
    u    = sx % 8;
    v    = sy % 8;
    if (mo) begin                                          // R8
      ga  = (int'(glyph_base) * 256 + idx * 8 + v) % 16384;
      val = (bank_byte(ga) >> (7 - u)) & 1;
      col = (at & 'hfe) | val;
    end else begin                                         // R6, R7
      if (at & 8) u = 7 - u;
      if (at & 4) v = 7 - v;
      if (at & 2) begin c = v; r = 7 - u; end
      else        begin c = u; r = v;     end
      ga  = (int'(glyph_base) * 256 + idx * 32 + r * 4 + c / 2) % 16384;
      val = (c % 2 == 0) ? (bank_byte(ga) >> 4) : (bank_byte(ga) & 15);
      col = (at & 'hf0) | val;
    end
    return (((col & 15) == int'(trans_idx)) ? 256 : 0) | col;   // R9
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit en, input int x, input int y, input bit mo, input string tag);
    int e;
    @(negedge clk);
    if (n >= LAT) begin
      int k;
      k = (n - LAT) % 8;
      chk(int'(pix_valid), int'(exp_v[k]), "R2 valid slot");
      if (exp_v[k]) begin
        chk(int'(pix_colour), exp_c[k], exp_tag[k]);
        chk(int'(pix_transparent), int'(exp_t[k]), "R9 transparent");
        last_c = exp_c[k];
        last_t = exp_t[k];
      end else begin
        chk(int'(pix_colour), last_c, "R10 hold colour");
        chk(int'(pix_transparent), int'(last_t), "R10 hold transparent");
      end
    end
    pix_en = en;
    pix_x  = 10'(x);
    pix_y  = 8'(y);
    mono   = mo;
    exp_v[n % 8]   = en;
    exp_tag[n % 8] = tag;
    if (en) begin
      e = expect_px(x, y, int'(wide), int'(mo));
      exp_c[n % 8] = e & 255;
      exp_t[n % 8] = (e >> 8) != 0;
    end
    n++;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'b0, 0, 0, mono, "idle");
  endtask

  task automatic sweep(input int y0, input int ystep, input int nl, input int mono_per,
                       input int gap_per, input string tag);
    int w;
    bit en, mo;
    w = wide ? 640 : 320;
    for (int l = 0; l < nl; l++) begin
      for (int x = 0; x < w; x++) begin
        en = !(gap_per > 0 && (x % gap_per) == gap_per - 1);
        mo = (mono_per > 0) ? bit'((x / mono_per) % 2) : mono;
        step(en, x, (y0 + l * ystep) % 256, mo, tag);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; pix_x = '0; pix_y = '0;
    wide = 1'b1; mono = 1'b0; scroll_x = '0; scroll_y = '0;
    map_base = '0; glyph_base = 6'd16; trans_idx = 4'd0;
    map_rdata = '0; glyph_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 while held
    chk(int'(pix_valid), 0, "R1 valid in reset");
    chk(int'(map_rd_en), 0, "R1 map strobe in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release, nothing requested
    chk(int'(pix_valid), 0, "R1 valid");
    chk(int'(pix_colour), 0, "R1 colour");
    chk(int'(pix_transparent), 0, "R1 transparent");
    chk(int'(map_rd_en), 0, "R1 map strobe");
    chk(int'(glyph_rd_en), 0, "R1 glyph strobe");

    idle(LAT + 3);
    // A: wide, 4-bit, no scroll, all in-cell lines of the first row
    sweep(0, 1, 8, 0, 0, "R5 R6 R7 colour wide");

    idle(8);
    wide = 1'b0; scroll_x = 10'd300; scroll_y = 8'd250;
    map_base = 6'd40; glyph_base = 6'd63; trans_idx = 4'd5;
    // B: narrow, both scrolls wrap, glyph addresses wrap the bank
    sweep(3, 37, 8, 0, 0, "R3 R4 R6 R7 colour scrolled");

    idle(8);
    wide = 1'b1; mono = 1'b1; scroll_x = 10'd1000; scroll_y = 8'd3;
    map_base = 6'd63; glyph_base = 6'd2; trans_idx = 4'd9;
    // C: monochrome, scroll beyond width, map addresses wrap
    sweep(250, 1, 8, 0, 0, "R3 R5 R8 colour mono");

    idle(8);
    wide = 1'b0; scroll_x = 10'd17; scroll_y = 8'd0;
    map_base = 6'd8; glyph_base = 6'd32; trans_idx = 4'd1;
    // D: mode flips between neighbours, with empty slots
    sweep(64, 1, 4, 13, 7, "R8 R10 R11 colour mixed");

    idle(LAT + 2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule